// File: doc/BRIEF.md
# Prioritized Exception Request Arbiter

This block gathers every exception request that can reach a small CPU core and reduces them to one selected request with its vector address. It watches a bank of peripheral maskable requests, one external active-low maskable pin (level or falling-edge sensed, with its own enable), one active-low non-maskable pin, and two instruction events: a software interrupt and an unimplemented-opcode trap. It owns the two condition-code mask bits I (maskable) and X (non-maskable pin) and applies the updates those bits receive on exception entry, on return-from-interrupt and on software writes.

Each source has a fixed vector address derived from the parameter `TOP_VEC`, and a higher address means higher priority: trap at `TOP_VEC`, software interrupt at `TOP_VEC-2`, non-maskable pin at `TOP_VEC-4`, external maskable pin at `TOP_VEC-6`, and peripheral source k at `TOP_VEC-8-2k`. A writable promotion byte lifts one maskable source to the top of the maskable group when it holds the low byte of that source's vector. The core takes a request by pulsing `vec_fetch` while `req_valid` is high. The block then applies the entry mask updates and re-arbitrates.

Three configuration addresses are written through `cfg_we`/`cfg_addr`/`cfg_wdata`. Address 0 is the promotion byte, reset to the external pin's vector low byte. Address 1 is pin control: bit0 selects edge mode (1) or level mode (0), bit1 is the pin enable, and writing 1 to bit2 clears the edge pending flag. Address 2 is the mask write: bit0 sets I and bit1 sets X.

Top module: `exc_arbiter`

## Requirements
- R1: Among the requests taken into account, the one with the highest vector address is output. The vectors are trap `TOP_VEC`, software interrupt `TOP_VEC-2`, non-maskable pin `TOP_VEC-4`, external pin `TOP_VEC-6`, and source k `TOP_VEC-8-2k`. With the defaults these are 0xFFF8, 0xFFF6, 0xFFF4, 0xFFF2 and 0xFFF0-2k.
- R2: When the promotion byte (address 0) equals the low byte of a pending, unmasked maskable source's vector, that source wins over every other maskable source but never over a non-maskable one.
- R3: A promotion byte that matches no maskable vector, or that matches a source that is not pending, leaves the default maskable order in force.
- R4: While I=1 no maskable request (peripheral or external pin) produces `req_valid`.
- R5: The non-maskable pin request is ignored while X=1. Software interrupt and trap events are latched until fetched and are never masked by I or X.
- R6: A mask write (address 2) sets I to bit0. It can clear X through bit1=0, but it never changes X from 0 to 1.
- R7: A fetch (`vec_fetch` with `req_valid`) sets I. It also sets X when the fetched vector is non-maskable (at or above `TOP_VEC-4`). `req_valid` is low in the cycle after a fetch.
- R8: `rti_evt` loads I and X from `rti_i` and `rti_x`.
- R9: In level mode the enabled external pin requests while it is low. It makes no request when disabled.
- R10: In edge mode a falling edge on the enabled pin sets a pending flag. The flag holds after the pin rises and is cleared by fetching the pin's vector or by writing 1 to bit2 of address 1.
- R11: After reset `req_valid`=0, I=1 and X=1.
- R12: `req_valid` and `req_vector` are registered: a change of a level request shows at the outputs one clock edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_req | input | N_SRC | Peripheral maskable level requests |
| ext_irq_n | input | 1 | External maskable pin, active low |
| nmi_n | input | 1 | Non-maskable pin, active low, level |
| swi_evt | input | 1 | Software-interrupt instruction event |
| trap_evt | input | 1 | Unimplemented-opcode trap event |
| vec_fetch | input | 1 | Core takes the presented vector |
| rti_evt | input | 1 | Return-from-interrupt executed |
| rti_i | input | 1 | I value restored by return |
| rti_x | input | 1 | X value restored by return |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration address |
| cfg_wdata | input | 8 | Configuration write data |
| req_valid | output | 1 | A request is selected |
| req_vector | output | VEC_W | Vector address of the selected request |
| mask_i | output | 1 | Maskable-interrupt mask bit |
| mask_x | output | 1 | Non-maskable pin mask bit |

## Verification
The bench builds the block with its defaults: eight peripheral sources and a top vector of 0xFFF8. This gives nine maskable vectors with distinct low bytes, from 0xF2 down to 0xE2. The lowest-priority source can then be promoted over the external pin and over the others, and the odd and unrelated promotion values 0xF1 and 0x55 exercise the no-match path. With this size every priority ordering, including all five tiers at once, can be reached with short vectors.

// File: rtl/exc_arb_pkg.sv
package exc_arb_pkg;
  typedef enum logic [1:0] {
    CFG_PROMO  = 2'd0,
    CFG_EXTCTL = 2'd1,
    CFG_MASK   = 2'd2
  } cfg_addr_e;

  localparam int unsigned EXT_EDGE_BIT = 0;
  localparam int unsigned EXT_EN_BIT   = 1;
  localparam int unsigned EXT_CLR_BIT  = 2;
  localparam int unsigned MASK_I_BIT   = 0;
  localparam int unsigned MASK_X_BIT   = 1;
endpackage

// File: rtl/exc_ext_pin.sv
module exc_ext_pin (
  input  logic clk,
  input  logic rst,
  input  logic pin_n,
  input  logic edge_mode,
  input  logic enable,
  input  logic clr,
  output logic req
);
  logic prev_q;
  logic pend_q;
  logic fall;

  assign fall = prev_q & ~pin_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b1;
      pend_q <= 1'b0;
    end else begin
      prev_q <= pin_n;
      if (edge_mode && fall)
        pend_q <= 1'b1;
      else if (clr || !edge_mode)
        pend_q <= 1'b0;
    end
  end

  assign req = enable & (edge_mode ? pend_q : ~pin_n);
endmodule

// File: rtl/exc_mask_bits.sv
module exc_mask_bits (
  input  logic       clk,
  input  logic       rst,
  input  logic       entry,
  input  logic       entry_nm,
  input  logic       rti,
  input  logic       rti_i,
  input  logic       rti_x,
  input  logic       wr,
  input  logic [1:0] wdata,
  output logic       mask_i,
  output logic       mask_x
);
  import exc_arb_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_i <= 1'b1;
      mask_x <= 1'b1;
    end else if (entry) begin
      mask_i <= 1'b1;
      if (entry_nm) mask_x <= 1'b1;
    end else if (rti) begin
      mask_i <= rti_i;
      mask_x <= rti_x;
    end else if (wr) begin
      mask_i <= wdata[MASK_I_BIT];
      mask_x <= mask_x & wdata[MASK_X_BIT];
    end
  end
endmodule

// File: rtl/exc_select.sv
module exc_select #(
  parameter int unsigned N_SRC = 8,
  parameter int unsigned VEC_W = 16,
  parameter logic [VEC_W-1:0] TOP_VEC = 16'hFFF8,
  localparam int unsigned NM = N_SRC + 1
) (
  input  logic             trap_pend,
  input  logic             swi_pend,
  input  logic             nmi_req,
  input  logic [NM-1:0]    mreq,
  input  logic [7:0]       promo,
  output logic             win_valid,
  output logic [VEC_W-1:0] win_vec
);
  localparam logic [VEC_W-1:0] V_TRAP = TOP_VEC;
  localparam logic [VEC_W-1:0] V_SWI  = TOP_VEC - VEC_W'(2);
  localparam logic [VEC_W-1:0] V_NMI  = TOP_VEC - VEC_W'(4);

  logic [VEC_W-1:0] mvec [NM];
  logic [NM-1:0]    match;

  for (genvar k = 0; k < NM; k++) begin : g_mvec
    assign mvec[k]  = TOP_VEC - VEC_W'(6) - VEC_W'(2 * k);
    assign match[k] = (mvec[k][7:0] == promo);
  end

  logic             dhit, phit;
  logic [VEC_W-1:0] dvec, pvec;

  always_comb begin
    dhit = 1'b0;
    dvec = '0;
    for (int k = NM - 1; k >= 0; k--) begin
      if (mreq[k]) begin
        dhit = 1'b1;
        dvec = mvec[k];
      end
    end
  end

  always_comb begin
    phit = 1'b0;
    pvec = '0;
    for (int k = 0; k < NM; k++) begin
      if (mreq[k] && match[k]) begin
        phit = 1'b1;
        pvec = mvec[k];
      end
    end
  end

  always_comb begin
    win_valid = 1'b1;
    if (trap_pend)     win_vec = V_TRAP;
    else if (swi_pend) win_vec = V_SWI;
    else if (nmi_req)  win_vec = V_NMI;
    else if (phit)     win_vec = pvec;
    else if (dhit)     win_vec = dvec;
    else begin
      win_valid = 1'b0;
      win_vec   = '0;
    end
  end
endmodule

// File: rtl/exc_arbiter.sv
module exc_arbiter #(
  parameter int unsigned N_SRC = 8,
  parameter int unsigned VEC_W = 16,
  parameter logic [VEC_W-1:0] TOP_VEC = 16'hFFF8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] src_req,
  input  logic             ext_irq_n,
  input  logic             nmi_n,
  input  logic             swi_evt,
  input  logic             trap_evt,
  input  logic             vec_fetch,
  input  logic             rti_evt,
  input  logic             rti_i,
  input  logic             rti_x,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_addr,
  input  logic [7:0]       cfg_wdata,
  output logic             req_valid,
  output logic [VEC_W-1:0] req_vector,
  output logic             mask_i,
  output logic             mask_x
);
  import exc_arb_pkg::*;

  localparam int unsigned NM = N_SRC + 1;
  localparam logic [VEC_W-1:0] V_TRAP = TOP_VEC;
  localparam logic [VEC_W-1:0] V_SWI  = TOP_VEC - VEC_W'(2);
  localparam logic [VEC_W-1:0] V_NMI  = TOP_VEC - VEC_W'(4);
  localparam logic [VEC_W-1:0] V_EXT  = TOP_VEC - VEC_W'(6);

  logic [7:0] promo_q;
  logic       edge_mode_q, ext_en_q;
  logic       swi_pend_q, trap_pend_q;
  logic       wr_promo, wr_ext, wr_mask;
  logic       taken, taken_nm, took_ext, took_swi, took_trap;
  logic       ext_req, ext_clr;
  logic [NM-1:0] mreq;
  logic       win_valid;
  logic [VEC_W-1:0] win_vec;

  assign wr_promo = cfg_we && (cfg_addr == CFG_PROMO);
  assign wr_ext   = cfg_we && (cfg_addr == CFG_EXTCTL);
  assign wr_mask  = cfg_we && (cfg_addr == CFG_MASK);

  assign taken     = vec_fetch & req_valid;
  assign taken_nm  = taken && (req_vector >= V_NMI);
  assign took_ext  = taken && (req_vector == V_EXT);
  assign took_swi  = taken && (req_vector == V_SWI);
  assign took_trap = taken && (req_vector == V_TRAP);
  assign ext_clr   = took_ext | (wr_ext & cfg_wdata[EXT_CLR_BIT]);

  always_ff @(posedge clk) begin
    if (rst) begin
      promo_q     <= V_EXT[7:0];
      edge_mode_q <= 1'b0;
      ext_en_q    <= 1'b0;
      swi_pend_q  <= 1'b0;
      trap_pend_q <= 1'b0;
    end else begin
      if (wr_promo) promo_q <= cfg_wdata;
      if (wr_ext) begin
        edge_mode_q <= cfg_wdata[EXT_EDGE_BIT];
        ext_en_q    <= cfg_wdata[EXT_EN_BIT];
      end
      if (swi_evt)       swi_pend_q <= 1'b1;
      else if (took_swi) swi_pend_q <= 1'b0;
      if (trap_evt)       trap_pend_q <= 1'b1;
      else if (took_trap) trap_pend_q <= 1'b0;
    end
  end

  exc_ext_pin u_ext (
    .clk       (clk),
    .rst       (rst),
    .pin_n     (ext_irq_n),
    .edge_mode (edge_mode_q),
    .enable    (ext_en_q),
    .clr       (ext_clr),
    .req       (ext_req)
  );

  exc_mask_bits u_mask (
    .clk      (clk),
    .rst      (rst),
    .entry    (taken),
    .entry_nm (taken_nm),
    .rti      (rti_evt),
    .rti_i    (rti_i),
    .rti_x    (rti_x),
    .wr       (wr_mask),
    .wdata    (cfg_wdata[1:0]),
    .mask_i   (mask_i),
    .mask_x   (mask_x)
  );

  assign mreq = {src_req, ext_req} & {NM{~mask_i}};

  exc_select #(
    .N_SRC   (N_SRC),
    .VEC_W   (VEC_W),
    .TOP_VEC (TOP_VEC)
  ) u_sel (
    .trap_pend (trap_pend_q),
    .swi_pend  (swi_pend_q),
    .nmi_req   (~nmi_n & ~mask_x),
    .mreq      (mreq),
    .promo     (promo_q),
    .win_valid (win_valid),
    .win_vec   (win_vec)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      req_valid  <= 1'b0;
      req_vector <= '0;
    end else begin
      req_valid  <= win_valid & ~taken;
      req_vector <= win_vec;
    end
  end
endmodule

// File: rtl/exc_arbiter_chk.sv
module exc_arbiter_chk #(
  parameter int unsigned N_SRC = 8,
  parameter int unsigned VEC_W = 16,
  parameter logic [VEC_W-1:0] TOP_VEC = 16'hFFF8
) (
  input logic             clk,
  input logic             rst,
  input logic [N_SRC-1:0] src_req,
  input logic             vec_fetch,
  input logic             rti_evt,
  input logic             rti_i,
  input logic             rti_x,
  input logic             cfg_we,
  input logic [1:0]       cfg_addr,
  input logic             req_valid,
  input logic [VEC_W-1:0] req_vector,
  input logic             mask_i,
  input logic             mask_x
);
  localparam logic [VEC_W-1:0] V_NMI = TOP_VEC - VEC_W'(4);

  logic unused_ok;
  assign unused_ok = ^src_req;

  assert_vec_range_R1: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> (req_vector <= TOP_VEC) && !req_vector[0]);

  assert_i_blocks_R4: assert property (@(posedge clk) disable iff (rst)
    (req_valid && $past(mask_i)) |-> (req_vector >= V_NMI));

  assert_x_no_set_R6: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && cfg_addr == 2'd2 && !mask_x && !vec_fetch && !rti_evt) |=> !mask_x);

  assert_entry_i_R7: assert property (@(posedge clk) disable iff (rst)
    (vec_fetch && req_valid) |=> mask_i);

  assert_entry_x_R7: assert property (@(posedge clk) disable iff (rst)
    (vec_fetch && req_valid && req_vector >= V_NMI) |=> mask_x);

  assert_fetch_drop_R7: assert property (@(posedge clk) disable iff (rst)
    (vec_fetch && req_valid) |=> !req_valid);

  assert_rti_load_R8: assert property (@(posedge clk) disable iff (rst)
    (rti_evt && !(vec_fetch && req_valid)) |=> (mask_i == $past(rti_i)) && (mask_x == $past(rti_x)));
endmodule

bind exc_arbiter exc_arbiter_chk #(
  .N_SRC   (N_SRC),
  .VEC_W   (VEC_W),
  .TOP_VEC (TOP_VEC)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .src_req    (src_req),
  .vec_fetch  (vec_fetch),
  .rti_evt    (rti_evt),
  .rti_i      (rti_i),
  .rti_x      (rti_x),
  .cfg_we     (cfg_we),
  .cfg_addr   (cfg_addr),
  .req_valid  (req_valid),
  .req_vector (req_vector),
  .mask_i     (mask_i),
  .mask_x     (mask_x)
);

// File: tb/sim_exc_arbiter.sv
module sim_exc_arbiter;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  src_req = '0;
  logic        ext_irq_n = 1'b1, nmi_n = 1'b1;
  logic        swi_evt = 1'b0, trap_evt = 1'b0, vec_fetch = 1'b0;
  logic        rti_evt = 1'b0, rti_i = 1'b0, rti_x = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_addr = '0;
  logic [7:0]  cfg_wdata = '0;
  logic        req_valid, mask_i, mask_x;
  logic [15:0] req_vector;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  exc_arbiter u0 (
    .clk(clk), .rst(rst), .src_req(src_req), .ext_irq_n(ext_irq_n), .nmi_n(nmi_n),
    .swi_evt(swi_evt), .trap_evt(trap_evt), .vec_fetch(vec_fetch),
    .rti_evt(rti_evt), .rti_i(rti_i), .rti_x(rti_x),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .req_valid(req_valid), .req_vector(req_vector), .mask_i(mask_i), .mask_x(mask_x)
  );

  // [33] ext pin active, [32:25] src_req, [24:17] promo, [16] valid, [15:0] vector
  localparam logic [33:0] TBL [12] = '{
    {1'b0, 8'h00, 8'hF2, 1'b0, 16'h0000},
    {1'b0, 8'h01, 8'hF2, 1'b1, 16'hFFF0},
    {1'b0, 8'h81, 8'hF2, 1'b1, 16'hFFF0},
    {1'b0, 8'h80, 8'hF2, 1'b1, 16'hFFE2},
    {1'b0, 8'h81, 8'hE2, 1'b1, 16'hFFE2},
    {1'b0, 8'h01, 8'hE2, 1'b1, 16'hFFF0},
    {1'b1, 8'h81, 8'hF2, 1'b1, 16'hFFF2},
    {1'b1, 8'h81, 8'hE2, 1'b1, 16'hFFE2},
    {1'b0, 8'h0C, 8'h55, 1'b1, 16'hFFEC},
    {1'b0, 8'h0C, 8'hEA, 1'b1, 16'hFFEA},
    {1'b1, 8'h00, 8'hF0, 1'b1, 16'hFFF2},
    {1'b0, 8'h0C, 8'hF1, 1'b1, 16'hFFEC}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cfg(input logic [1:0] a, input logic [7:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic fetch();
    vec_fetch = 1'b1;
    @(negedge clk);
    vec_fetch = 1'b0;
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    tick(4);
    rst = 1'b0;
    tick(1);
    chk("R11 valid after reset", 32'(req_valid), 32'd0);
    chk("R11 I after reset", 32'(mask_i), 32'd1);
    chk("R11 X after reset", 32'(mask_x), 32'd1);

    src_req = 8'h01;
    tick(3);
    chk("R4 maskable blocked by I", 32'(req_valid), 32'd0);
    nmi_n = 1'b0;
    tick(3);
    chk("R5 nmi blocked by X", 32'(req_valid), 32'd0);
    nmi_n = 1'b1;
    src_req = 8'h00;

    cfg(2'd2, 8'h02);
    cfg(2'd1, 8'h02);
    tick(1);
    chk("R6 I cleared by write", 32'(mask_i), 32'd0);

    for (int r = 0; r < 12; r++) begin
      ext_irq_n = ~TBL[r][33];
      src_req   = TBL[r][32:25];
      cfg(2'd0, TBL[r][24:17]);
      tick(3);
      chk($sformatf("R1 R2 R3 R9 row %0d valid", r), 32'(req_valid), 32'(TBL[r][16]));
      if (TBL[r][16])
        chk($sformatf("R1 R2 R3 R9 row %0d vector", r), 32'(req_vector), 32'(TBL[r][15:0]));
    end
    ext_irq_n = 1'b1; src_req = 8'h00;
    cfg(2'd0, 8'hF2);

    cfg(2'd1, 8'h00);
    ext_irq_n = 1'b0;
    tick(3);
    chk("R9 disabled pin no request", 32'(req_valid), 32'd0);
    ext_irq_n = 1'b1;

    src_req = 8'h01;
    tick(3);
    fetch();
    chk("R7 valid drops after fetch", 32'(req_valid), 32'd0);
    chk("R7 entry sets I", 32'(mask_i), 32'd1);
    tick(3);
    chk("R4 held off after entry", 32'(req_valid), 32'd0);
    src_req = 8'h00;

    cfg(2'd2, 8'h00);
    tick(1);
    chk("R6 X cleared by write", 32'(mask_x), 32'd0);
    cfg(2'd2, 8'h03);
    tick(1);
    chk("R6 X not set by write", 32'(mask_x), 32'd0);
    chk("R6 I set by write", 32'(mask_i), 32'd1);

    src_req = 8'h01;
    nmi_n = 1'b0;
    tick(3);
    chk("R5 nmi over I", 32'(req_vector), 32'hFFF4);
    fetch();
    nmi_n = 1'b1;
    chk("R7 nm entry sets X", 32'(mask_x), 32'd1);
    rti_evt = 1'b1; rti_i = 1'b0; rti_x = 1'b0;
    tick(1);
    rti_evt = 1'b0;
    chk("R8 rti restores I", 32'(mask_i), 32'd0);
    chk("R8 rti restores X", 32'(mask_x), 32'd0);
    tick(3);
    chk("R8 maskable after return", 32'(req_vector), 32'hFFF0);
    src_req = 8'h00;

    cfg(2'd2, 8'h01);
    swi_evt = 1'b1;
    tick(1);
    swi_evt = 1'b0;
    tick(3);
    chk("R5 swi ignores I", 32'(req_vector), 32'hFFF6);
    trap_evt = 1'b1;
    tick(1);
    trap_evt = 1'b0;
    tick(3);
    chk("R1 trap over swi", 32'(req_vector), 32'hFFF8);
    fetch();
    tick(3);
    chk("R5 swi still latched", 32'(req_vector), 32'hFFF6);
    fetch();
    tick(3);
    chk("R5 latches cleared by fetch", 32'(req_valid), 32'd0);

    cfg(2'd2, 8'h00);
    cfg(2'd1, 8'h03);
    ext_irq_n = 1'b0;
    tick(1);
    ext_irq_n = 1'b1;
    tick(3);
    chk("R10 edge latched", 32'(req_valid), 32'd1);
    chk("R10 edge vector", 32'(req_vector), 32'hFFF2);
    fetch();
    cfg(2'd2, 8'h00);
    tick(3);
    chk("R10 fetch clears edge", 32'(req_valid), 32'd0);
    ext_irq_n = 1'b0;
    tick(1);
    ext_irq_n = 1'b1;
    tick(3);
    chk("R10 second edge", 32'(req_vector), 32'hFFF2);
    cfg(2'd1, 8'h07);
    tick(3);
    chk("R10 software clear", 32'(req_valid), 32'd0);

    chk("R12 idle before request", 32'(req_valid), 32'd0);
    src_req = 8'h02;
    tick(1);
    chk("R12 one edge latency valid", 32'(req_valid), 32'd1);
    chk("R12 one edge latency vector", 32'(req_vector), 32'hFFEE);
    src_req = 8'h00;

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule